// File: doc/BRIEF.md
# H-Bridge PWM Steering Driver

This block produces the two gate-side inputs of an H-bridge motor driver from a drive magnitude and a signed error. A free-running counter serves as the ramp of a compare-type pulse-width modulator. The output is high while the ramp value is below the latched duty value, so the number of high cycles per period equals the requested magnitude. The sign of the error selects which bridge input carries the pulse train; the other input stays low.

Near zero error the block holds the bridge off. Drive stops once the error magnitude drops under a low threshold. It starts again only after the error rises above a higher threshold, so a small, noisy error cannot toggle the motor on and off. The direction is latched and can only change while the bridge is off. A sign reversal during drive therefore passes through a short interval with both inputs low before the opposite input is driven. A new duty value is taken only at the ramp wrap, so a pulse in progress always completes at its original length.

Top module: `hbridge_pwm_drive`

## Requirements
- R1: While `rst` is high, and in the first sample after it is released, both `bridge_a` and `bridge_b` are low.
- R2: The ramp runs from 0 to PERIOD-1 and then wraps to 0. With a constant mid-range drive value, consecutive rising edges of the active bridge input are exactly PERIOD cycles apart.
- R3: With a steady drive value d where 0 < d < PERIOD and drive enabled, the active input is high for exactly d cycles in every window of PERIOD consecutive cycles.
- R4: A drive value of 0 keeps the active input constantly low. A drive value of PERIOD or more keeps it constantly high.
- R5: A new drive value takes effect only at the ramp wrap. Every complete high pulse has the length of either the old value or the new value, never an intermediate length.
- R6: Direction encoding: `err_neg` = 0 routes the PWM to `bridge_a` and holds `bridge_b` low. `err_neg` = 1 routes the PWM to `bridge_b` and holds `bridge_a` low.
- R7: While drive is enabled, an error magnitude below LO_TH disables it, and both inputs are low two cycles after the low error is presented. A magnitude of LO_TH or more keeps drive enabled.
- R8: While drive is disabled, drive restarts only for an error magnitude strictly above HI_TH. A magnitude in the band LO_TH..HI_TH keeps the bridge off.
- R9: `bridge_a` and `bridge_b` are never high in the same cycle. A sign reversal during drive yields exactly two cycles with both inputs low before the opposite input goes high (with the drive value at PERIOD or more).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| drive_mag | input | CTRL_W | Requested high time per period, in cycles |
| err_neg | input | 1 | Error sign: 0 routes drive to `bridge_a`, 1 to `bridge_b` |
| err_mag | input | ERR_W | Magnitude of the control error |
| bridge_a | output | 1 | Registered H-bridge input A |
| bridge_b | output | 1 | Registered H-bridge input B |

## Verification
The properties assume synchronous inputs, and they assume CTRL_W is at least the ramp width so the compare is lossless. They place no restriction on how fast the sign or the error magnitude may change, since the steering logic must tolerate arbitrary jumps. The stimulus runs a small configuration with a 16-cycle ramp. It changes inputs only on the falling clock edge. It sweeps every drive value from 0 past the period, every error magnitude across both thresholds from both the enabled and the disabled state, and every ramp phase at which a drive change can arrive.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

  // Which bridge input carries the modulated drive.
  typedef enum logic {
    HBD_SIDE_A = 1'b0,
    HBD_SIDE_B = 1'b1
  } hbd_side_e;

  localparam int HBD_NUM_SIDES = 2;

endpackage

// File: rtl/hbd_ramp.sv
module hbd_ramp #(
  parameter int PERIOD = 64000,
  parameter int CNT_W  = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] ramp_o,
  output logic             wrap_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] ramp_q;

  assign wrap_o = (ramp_q == LAST);
  assign ramp_o = ramp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ramp_q <= '0;
    end else if (wrap_o) begin
      ramp_q <= '0;
    end else begin
      ramp_q <= ramp_q + 1'b1;
    end
  end

endmodule

// File: rtl/hbd_duty.sv
module hbd_duty #(
  parameter int CTRL_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrap_i,
  input  logic [CNT_W-1:0]  ramp_i,
  input  logic [CTRL_W-1:0] level_i,
  output logic [CTRL_W-1:0] duty_o,
  output logic              pwm_o
);

  logic [CTRL_W-1:0] duty_q;
  logic [CTRL_W-1:0] ramp_ext;

  // Widen the ramp so the compare covers every drive value.
  assign ramp_ext = CTRL_W'(ramp_i);

  // The duty value is only replaced at the wrap, so pulses complete.
  always_ff @(posedge clk) begin
    if (rst) begin
      duty_q <= '0;
    end else if (wrap_i) begin
      duty_q <= level_i;
    end
  end

  assign duty_o = duty_q;
  assign pwm_o  = (ramp_ext < duty_q);

endmodule

// File: rtl/hbd_steer.sv
module hbd_steer
  import hbd_pkg::*;
#(
  parameter int ERR_W = 16,
  parameter int LO_TH = 100,
  parameter int HI_TH = 300
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sign_i,
  input  logic [ERR_W-1:0] err_i,
  output logic             run_o,
  output hbd_side_e        side_o
);

  localparam logic [ERR_W-1:0] LO_LIM = ERR_W'(LO_TH);
  localparam logic [ERR_W-1:0] HI_LIM = ERR_W'(HI_TH);

  logic      run_q;
  hbd_side_e side_q;
  logic      sign_match;
  logic      run_d;

  assign sign_match = (hbd_side_e'(sign_i) == side_q);

  // Hysteresis: stay on down to LO_LIM, start only above HI_LIM.
  // A sign that disagrees with the latched side forces the bridge off.
  always_comb begin
    if (run_q) begin
      run_d = sign_match && (err_i >= LO_LIM);
    end else begin
      run_d = sign_match && (err_i > HI_LIM);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      side_q <= HBD_SIDE_A;
    end else begin
      run_q <= run_d;
      if (!run_q) begin
        side_q <= hbd_side_e'(sign_i);
      end
    end
  end

  assign run_o  = run_q;
  assign side_o = side_q;

endmodule

// File: rtl/hbridge_pwm_drive.sv
module hbridge_pwm_drive
  import hbd_pkg::*;
#(
  parameter int PERIOD = 64000,
  parameter int CTRL_W = 16,
  parameter int ERR_W  = 16,
  parameter int LO_TH  = 100,
  parameter int HI_TH  = 300
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CTRL_W-1:0] drive_mag,
  input  logic              err_neg,
  input  logic [ERR_W-1:0]  err_mag,
  output logic              bridge_a,
  output logic              bridge_b
);

  localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [CNT_W-1:0]  ramp_w;
  logic              wrap_w;
  logic [CTRL_W-1:0] duty_w;
  logic              pwm_w;
  logic              run_w;
  hbd_side_e         side_w;
  logic [HBD_NUM_SIDES-1:0] pin_q;

  hbd_ramp #(
    .PERIOD (PERIOD),
    .CNT_W  (CNT_W)
  ) u_ramp (
    .clk    (clk),
    .rst    (rst),
    .ramp_o (ramp_w),
    .wrap_o (wrap_w)
  );

  hbd_duty #(
    .CTRL_W (CTRL_W),
    .CNT_W  (CNT_W)
  ) u_duty (
    .clk     (clk),
    .rst     (rst),
    .wrap_i  (wrap_w),
    .ramp_i  (ramp_w),
    .level_i (drive_mag),
    .duty_o  (duty_w),
    .pwm_o   (pwm_w)
  );

  hbd_steer #(
    .ERR_W (ERR_W),
    .LO_TH (LO_TH),
    .HI_TH (HI_TH)
  ) u_steer (
    .clk    (clk),
    .rst    (rst),
    .sign_i (err_neg),
    .err_i  (err_mag),
    .run_o  (run_w),
    .side_o (side_w)
  );

  // One registered output per bridge side; only the latched side may drive.
  for (genvar s = 0; s < HBD_NUM_SIDES; s++) begin : g_side
    always_ff @(posedge clk) begin
      if (rst) begin
        pin_q[s] <= 1'b0;
      end else begin
        pin_q[s] <= run_w && pwm_w && (side_w == hbd_side_e'(s));
      end
    end
  end

  assign bridge_a = pin_q[HBD_SIDE_A];
  assign bridge_b = pin_q[HBD_SIDE_B];

endmodule

// File: rtl/hbd_checker.sv
module hbd_checker #(
  parameter int PERIOD = 64000,
  parameter int CTRL_W = 16,
  parameter int ERR_W  = 16,
  parameter int LO_TH  = 100,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              bridge_a,
  input logic              bridge_b,
  input logic [ERR_W-1:0]  err_mag,
  input logic [CNT_W-1:0]  ramp,
  input logic [CTRL_W-1:0] duty
);

  // R9: the two bridge inputs are mutually exclusive.
  p_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    !(bridge_a && bridge_b));

  // R9: a side may only start after the other side was low.
  p_gap_a_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(bridge_a) |-> !$past(bridge_b));
  p_gap_b_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(bridge_b) |-> !$past(bridge_a));

  // R2: ramp stays inside its period.
  p_ramp_range_r2: assert property (@(posedge clk) disable iff (rst)
    32'(ramp) < PERIOD);

  // R5: the duty value changes only following the last ramp step.
  p_duty_at_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(duty) |-> (32'($past(ramp)) == PERIOD - 1));

  // R7: a small error turns both inputs off two cycles later.
  p_small_err_off_r7: assert property (@(posedge clk) disable iff (rst)
    (32'(err_mag) < LO_TH) |-> ##2 (!bridge_a && !bridge_b));

endmodule

bind hbridge_pwm_drive hbd_checker #(
  .PERIOD (PERIOD),
  .CTRL_W (CTRL_W),
  .ERR_W  (ERR_W),
  .LO_TH  (LO_TH),
  .CNT_W  (CNT_W)
) u_hbd_checker (
  .clk      (clk),
  .rst      (rst),
  .bridge_a (bridge_a),
  .bridge_b (bridge_b),
  .err_mag  (err_mag),
  .ramp     (ramp_w),
  .duty     (duty_w)
);

// File: tb/hbridge_pwm_drive_bench.sv
module hbridge_pwm_drive_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PER    = 16;
  localparam int CTRL_W = 5;
  localparam int ERR_W  = 6;
  localparam int LO     = 4;
  localparam int HI     = 10;
  localparam int BIG    = 20;
  localparam int WATCHDOG_CYCLES = 150000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [CTRL_W-1:0] drive_mag = '0;
  logic              err_neg = 1'b0;
  logic [ERR_W-1:0]  err_mag = '0;
  logic              bridge_a;
  logic              bridge_b;

  int checks = 0;
  int errors = 0;
  int cycle  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hbridge_pwm_drive #(
    .PERIOD (PER),
    .CTRL_W (CTRL_W),
    .ERR_W  (ERR_W),
    .LO_TH  (LO),
    .HI_TH  (HI)
  ) u_hbridge_pwm_drive (
    .clk       (clk),
    .rst       (rst),
    .drive_mag (drive_mag),
    .err_neg   (err_neg),
    .err_mag   (err_mag),
    .bridge_a  (bridge_a),
    .bridge_b  (bridge_b)
  );

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cycle++;
    end
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cycle);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Count high samples of each side over one full period.
  task automatic count_window(output int na, output int nb);
    na = 0;
    nb = 0;
    for (int i = 0; i < PER; i++) begin
      step(1);
      na += int'(bridge_a);
      nb += int'(bridge_b);
    end
  endtask

  initial begin
    int na, nb, exp, t0, t1, run, longs;
    bit prev, ok, armed;

    // R1: reset state
    step(1);
    check(!bridge_a && !bridge_b, "R1 during reset", {bridge_a, bridge_b}, 0);
    step(4);
    rst = 1'b0;
    step(1);
    check(!bridge_a && !bridge_b, "R1 after release", {bridge_a, bridge_b}, 0);

    // R3/R4/R6: duty sweep on both sides
    for (int side = 0; side < 2; side++) begin
      for (int d = 0; d <= PER + 2; d++) begin
        drive_mag = CTRL_W'(d);
        err_neg   = side[0];
        err_mag   = ERR_W'(BIG);
        step(2 * PER + 4);
        count_window(na, nb);
        exp = (d >= PER) ? PER : d;
        if (side == 0) begin
          check(na == exp, "R3/R4 duty on bridge_a", na, exp);
          check(nb == 0, "R6 bridge_b idle when err_neg=0", nb, 0);
        end else begin
          check(nb == exp, "R3/R4 duty on bridge_b", nb, exp);
          check(na == 0, "R6 bridge_a idle when err_neg=1", na, 0);
        end
      end
    end
    drive_mag = 5'd31;
    err_neg   = 1'b0;
    step(2 * PER + 4);
    count_window(na, nb);
    check(na == PER, "R4 maximum code constant high", na, PER);

    // R2: rising edges exactly one period apart
    drive_mag = 5'd5;
    step(2 * PER + 4);
    prev = bridge_a;
    t0 = -1;
    t1 = -1;
    for (int i = 0; i < 3 * PER && t1 < 0; i++) begin
      step(1);
      if (bridge_a && !prev) begin
        if (t0 < 0) t0 = cycle;
        else t1 = cycle;
      end
      prev = bridge_a;
    end
    check((t1 - t0) == PER, "R2 period between rising edges", t1 - t0, PER);

    // R5: change the drive value at every phase of the ramp
    for (int off = 0; off < PER; off++) begin
      drive_mag = 5'd5;
      err_neg   = 1'b0;
      err_mag   = ERR_W'(BIG);
      step(3 * PER);
      step(off);
      drive_mag = 5'd11;
      ok    = 1'b1;
      armed = 1'b0;
      run   = 0;
      longs = 0;
      for (int i = 0; i < 4 * PER; i++) begin
        step(1);
        if (!bridge_a) begin
          if (armed && run > 0) begin
            if (run != 5 && run != 11) ok = 1'b0;
            if (run == 11) longs++;
          end
          armed = 1'b1;
          run   = 0;
        end else begin
          run++;
        end
      end
      check(ok && longs > 0, "R5 pulses keep whole length", run, 11);
    end

    // R7/R8: hysteresis thresholds from both starting states
    drive_mag = 5'd16;
    err_neg   = 1'b0;
    for (int e = 0; e <= BIG; e++) begin
      err_mag = ERR_W'(BIG);
      step(6);
      err_mag = ERR_W'(e);
      step(4);
      exp = (e >= LO) ? 1 : 0;
      check(int'(bridge_a) == exp, "R7 stay-on threshold", int'(bridge_a), exp);
      err_mag = '0;
      step(6);
      err_mag = ERR_W'(e);
      step(4);
      exp = (e > HI) ? 1 : 0;
      check(int'(bridge_a) == exp, "R8 restart threshold", int'(bridge_a), exp);
    end

    // R7: two-cycle latency to both-low
    err_mag = ERR_W'(BIG);
    step(6);
    err_mag = ERR_W'(LO - 1);
    step(1);
    check(bridge_a, "R7 still on one cycle later", int'(bridge_a), 1);
    step(1);
    check(!bridge_a && !bridge_b, "R7 off two cycles later", {bridge_a, bridge_b}, 0);

    // R9: sign reversal while driving
    err_mag = ERR_W'(BIG);
    err_neg = 1'b0;
    step(6);
    err_neg = 1'b1;
    step(1);
    check(bridge_a && !bridge_b, "R9 reversal cycle 1", {bridge_a, bridge_b}, 2);
    step(1);
    check(!bridge_a && !bridge_b, "R9 reversal cycle 2", {bridge_a, bridge_b}, 0);
    step(1);
    check(!bridge_a && !bridge_b, "R9 reversal cycle 3", {bridge_a, bridge_b}, 0);
    step(1);
    check(!bridge_a && bridge_b, "R9 reversal cycle 4", {bridge_a, bridge_b}, 1);
    err_neg = 1'b0;
    ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      step(1);
      if (bridge_a && bridge_b) ok = 1'b0;
    end
    check(ok && bridge_a, "R9 reversal back to bridge_a", {bridge_a, bridge_b}, 2);

    done = 1'b1;
    finish_run();
  end

  initial begin
    for (int i = 0; i < WATCHDOG_CYCLES; i++) begin
      @(posedge clk);
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG_CYCLES, 0);
      finish_run();
    end
  end

endmodule